// File: doc/BRIEF.md
# Monitor Channel Receive Interrupt Controller

This block sits on the receive side of a frame-based serial management channel. Once per frame it samples a byte lane and a handshake flag from the sender. A falling edge of that flag, seen from one frame to the next, marks a new byte. The block decides whether to store the byte and whether to raise a data-received status. It drives a receiver acknowledge flag back to the sender. It also detects the end of a packet and a receive overrun.

Three enables set the behaviour:
- The receive-interrupt enable and the acknowledge-control enable together pick one of three data modes: silent, first byte of each packet only, or every byte stored.
- The acknowledge-control enable also decides whether the acknowledge flag follows the handshake or stays idle.
- The event enable gates end-of-packet, acknowledge-complete and abort status into the interrupt line.

Status flags are sticky. They clear only on a read/clear strobe from the host side.

Top module: `mchan_rx_ctrl`

## Requirements
- R1: While `en_rx_irq` is 0, `st_data_rx` is never set and `data_out` never changes, not even for the first byte of a packet.
- R2: With `en_rx_irq`=1 and `en_ack_ctrl`=0, only the first byte of a packet is stored and flagged. Later bytes of the same packet leave `data_out` and `st_data_rx` unchanged.
- R3: With `en_rx_irq`=1 and `en_ack_ctrl`=1, every byte is stored in `data_out` and sets `st_data_rx`. `data_out` changes only on a cycle that carries `frame_stb`.
- R4: `sender_flag` and `rx_byte` are sampled only in cycles with `frame_stb`=1. A byte is recognised when the sampled flag is 0 and the previous sampled flag was 1. The flag reads as 1 after reset. Without a strobe, the inputs have no effect.
- R5: With `en_ack_ctrl`=0, `ack_flag` is 1. With `en_ack_ctrl`=1:
  - `ack_flag` goes to 0 after the strobe that stores a byte.
  - It returns to 1 after the next strobe that samples `sender_flag`=1.
  - That same strobe sets `st_acked`.
- R6: After a byte has started a packet, two consecutive strobes that sample `sender_flag`=1 set `st_end`. The next byte after that counts as the first byte of a new packet.
- R7: If a byte that would be stored arrives while the previously stored byte is unread, the following happens:
  - `st_abort` is set.
  - The byte is dropped, so `data_out` keeps its value.
  - `ack_flag` is held at 1 for the next two strobes.
  
  A byte counts as read once `rd_clr` has pulsed since it was stored. A `rd_clr` in the same cycle as the new byte counts as a read first.
- R8: `irq` is (`st_data_rx` AND `en_rx_irq`) OR ((`st_end` OR `st_acked` OR `st_abort`) AND `en_evt_irq`). With `en_evt_irq`=0, the last three flags never assert `irq`.
- R9: The four status flags are sticky, and `rd_clr` clears all of them. A flag being set in the same cycle as `rd_clr` ends up set.
- R10: After synchronous reset:
  - all flags are 0
  - `irq` is 0
  - `data_out` is 0
  - `ack_flag` is 1

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse, once per frame |
| rx_byte | input | DATA_W | Received channel byte |
| sender_flag | input | 1 | Sender handshake flag, 1 = idle |
| en_rx_irq | input | 1 | Data-received enable |
| en_ack_ctrl | input | 1 | Every-byte mode and acknowledge control |
| en_evt_irq | input | 1 | Enable for end, acknowledge and abort events |
| rd_clr | input | 1 | Read/clear strobe for status and stored byte |
| data_out | output | DATA_W | Stored byte |
| ack_flag | output | 1 | Receiver acknowledge, 0 = acknowledged |
| st_data_rx | output | 1 | Data-received status |
| st_end | output | 1 | End-of-packet status |
| st_acked | output | 1 | Acknowledge-complete status |
| st_abort | output | 1 | Overrun abort status |
| irq | output | 1 | Combined interrupt |

## Verification
Two cases can fall in the same clock edge: the host's read/clear strobe, and a frame strobe that brings a new byte or sets a flag.

The bench provokes this by pulsing `rd_clr` in the very cycle of a frame strobe that carries a falling sender flag. An unread byte is pending at that point. The bench then judges two outcomes:
- the new byte must be stored with no abort, since the read counts first;
- the freshly set data flag must survive the clear, while the older acknowledge flag is wiped.

A separate case checks the other side: a byte arriving with no read at all must give an abort with `data_out` unchanged.

// File: rtl/mchan_pkg.sv
package mchan_pkg;

    // Data-path mode selected by the two receive enables
    typedef enum logic [1:0] {
        RXM_OFF   = 2'd0,
        RXM_FIRST = 2'd1,
        RXM_EVERY = 2'd2
    } rx_mode_e;

    // One-cycle events that feed the sticky status register
    typedef struct packed {
        logic stored;
        logic pkt_end;
        logic acked;
        logic abort;
    } rx_evt_t;

    function automatic rx_mode_e decode_mode(input logic en_rx, input logic en_ack);
        rx_mode_e m;
        if (!en_rx)      m = RXM_OFF;
        else if (en_ack) m = RXM_EVERY;
        else             m = RXM_FIRST;
        return m;
    endfunction

endpackage

// File: rtl/mchan_edge.sv
// Frame-rate sampling of the sender flag: byte edges and end-of-packet
module mchan_edge #(
    parameter int unsigned END_FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_stb,
    input  logic flag_in,
    output logic byte_fall,
    output logic byte_rise,
    output logic pkt_end
);
    localparam int unsigned CW = $clog2(END_FRAMES + 1);
    localparam logic [CW-1:0] END_LAST = CW'(END_FRAMES - 1);

    logic          flag_q;
    logic          pkt_q;
    logic [CW-1:0] hi_cnt;

    always_comb begin
        byte_fall = frame_stb &  flag_q & ~flag_in;
        byte_rise = frame_stb & ~flag_q &  flag_in;
        pkt_end   = frame_stb &  flag_in & pkt_q & (hi_cnt == END_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b1;
            pkt_q  <= 1'b0;
            hi_cnt <= '0;
        end else if (frame_stb) begin
            flag_q <= flag_in;
            if (!flag_in) begin
                hi_cnt <= '0;
                if (byte_fall) pkt_q <= 1'b1;
            end else if (pkt_q) begin
                if (pkt_end) begin
                    pkt_q  <= 1'b0;
                    hi_cnt <= '0;
                end else begin
                    hi_cnt <= hi_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mchan_store.sv
// Store decision, data register, unread tracking and overrun detect
module mchan_store
    import mchan_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_fall,
    input  logic              pkt_end,
    input  logic [DATA_W-1:0] rx_byte,
    input  rx_mode_e          mode,
    input  logic              rd_clr,
    output logic [DATA_W-1:0] data_q,
    output logic              stored,
    output logic              abort
);
    logic first_seen_q;
    logic pend_q;
    logic want;
    logic pend_eff;

    always_comb begin
        unique case (mode)
            RXM_EVERY: want = 1'b1;
            RXM_FIRST: want = ~first_seen_q;
            default:   want = 1'b0;
        endcase
        // a read in the same cycle counts before the new byte
        pend_eff = pend_q & ~rd_clr;
        stored   = byte_fall & want & ~pend_eff;
        abort    = byte_fall & want &  pend_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            first_seen_q <= 1'b0;
            pend_q       <= 1'b0;
            data_q       <= '0;
        end else begin
            if (pkt_end)        first_seen_q <= 1'b0;
            else if (byte_fall) first_seen_q <= 1'b1;

            if (stored)      pend_q <= 1'b1;
            else if (rd_clr) pend_q <= 1'b0;

            if (stored) data_q <= rx_byte;
        end
    end
endmodule

// File: rtl/mchan_ack.sv
// Receiver acknowledge flag with abort hold-off
module mchan_ack #(
    parameter int unsigned HOLD_FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_stb,
    input  logic en_ack,
    input  logic stored,
    input  logic abort,
    input  logic byte_rise,
    output logic ack_out,
    output logic acked
);
    localparam int unsigned HW = $clog2(HOLD_FRAMES + 1);
    localparam logic [HW-1:0] HOLD_INIT = HW'(HOLD_FRAMES);

    logic          ack_q;
    logic [HW-1:0] hold_q;

    always_comb begin
        acked   = frame_stb & en_ack & byte_rise & ~ack_q & (hold_q == '0);
        ack_out = ack_q | ~en_ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q  <= 1'b1;
            hold_q <= '0;
        end else if (!en_ack) begin
            ack_q  <= 1'b1;
            hold_q <= '0;
        end else if (frame_stb) begin
            if (abort) begin
                ack_q  <= 1'b1;
                hold_q <= HOLD_INIT;
            end else if (hold_q != '0) begin
                ack_q  <= 1'b1;
                hold_q <= hold_q - 1'b1;
            end else if (stored) begin
                ack_q <= 1'b0;
            end else if (byte_rise) begin
                ack_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mchan_status.sv
// Sticky status flags and interrupt combine
module mchan_status
    import mchan_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rx_evt_t evt,
    input  logic    rd_clr,
    input  logic    en_rx,
    input  logic    en_evt,
    output rx_evt_t flags,
    output logic    irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            // set has priority over a coincident clear
            flags <= (flags & {4{~rd_clr}}) | evt;
        end
    end

    always_comb begin
        irq = (flags.stored & en_rx)
            | ((flags.pkt_end | flags.acked | flags.abort) & en_evt);
    end
endmodule

// File: rtl/mchan_rx_ctrl.sv
module mchan_rx_ctrl
    import mchan_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned END_FRAMES  = 2,
    parameter int unsigned HOLD_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              sender_flag,
    input  logic              en_rx_irq,
    input  logic              en_ack_ctrl,
    input  logic              en_evt_irq,
    input  logic              rd_clr,
    output logic [DATA_W-1:0] data_out,
    output logic              ack_flag,
    output logic              st_data_rx,
    output logic              st_end,
    output logic              st_acked,
    output logic              st_abort,
    output logic              irq
);
    rx_mode_e mode;
    rx_evt_t  evt;
    rx_evt_t  flags;
    logic     byte_fall, byte_rise, pkt_end;
    logic     stored, abort, acked;

    assign mode = decode_mode(en_rx_irq, en_ack_ctrl);

    mchan_edge #(.END_FRAMES(END_FRAMES)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .flag_in   (sender_flag),
        .byte_fall (byte_fall),
        .byte_rise (byte_rise),
        .pkt_end   (pkt_end)
    );

    mchan_store #(.DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .byte_fall (byte_fall),
        .pkt_end   (pkt_end),
        .rx_byte   (rx_byte),
        .mode      (mode),
        .rd_clr    (rd_clr),
        .data_q    (data_out),
        .stored    (stored),
        .abort     (abort)
    );

    mchan_ack #(.HOLD_FRAMES(HOLD_FRAMES)) u_ack (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .en_ack    (en_ack_ctrl),
        .stored    (stored),
        .abort     (abort),
        .byte_rise (byte_rise),
        .ack_out   (ack_flag),
        .acked     (acked)
    );

    always_comb begin
        evt.stored  = stored;
        evt.pkt_end = pkt_end;
        evt.acked   = acked;
        evt.abort   = abort;
    end

    mchan_status u_status (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .rd_clr (rd_clr),
        .en_rx  (en_rx_irq),
        .en_evt (en_evt_irq),
        .flags  (flags),
        .irq    (irq)
    );

    assign st_data_rx = flags.stored;
    assign st_end     = flags.pkt_end;
    assign st_acked   = flags.acked;
    assign st_abort   = flags.abort;
endmodule

// File: rtl/mchan_rx_chk.sv
module mchan_rx_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_stb,
    input logic              en_rx_irq,
    input logic              en_ack_ctrl,
    input logic              en_evt_irq,
    input logic              rd_clr,
    input logic [DATA_W-1:0] data_out,
    input logic              ack_flag,
    input logic              st_data_rx,
    input logic              st_end,
    input logic              st_acked,
    input logic              st_abort,
    input logic              irq
);
    AST_OFF_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        !en_rx_irq |=> !$rose(st_data_rx)); // R1

    AST_DATA_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_stb) |-> $stable(data_out)); // R3

    AST_FLAGS_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        ($rose(st_data_rx) || $rose(st_end) || $rose(st_acked) || $rose(st_abort))
        |-> $past(frame_stb)); // R4

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_flag) |-> ($past(frame_stb) && $past(en_ack_ctrl))); // R5

    AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (rst)
        $rose(st_abort) |-> ($stable(data_out) && ack_flag)); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!en_rx_irq && !en_evt_irq) |-> !irq); // R8

    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !frame_stb) |=> !(st_data_rx || st_end || st_acked || st_abort)); // R9
endmodule

bind mchan_rx_ctrl mchan_rx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mchan_rx_ctrl.sv
module tb_mchan_rx_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_stb = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       sender_flag = 1'b1;
    logic       en_rx_irq = 1'b0, en_ack_ctrl = 1'b0, en_evt_irq = 1'b0;
    logic       rd_clr = 1'b0;
    logic [7:0] data_out;
    logic       ack_flag, st_data_rx, st_end, st_acked, st_abort, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mchan_rx_ctrl dut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .rx_byte(rx_byte),
        .sender_flag(sender_flag), .en_rx_irq(en_rx_irq), .en_ack_ctrl(en_ack_ctrl),
        .en_evt_irq(en_evt_irq), .rd_clr(rd_clr), .data_out(data_out),
        .ack_flag(ack_flag), .st_data_rx(st_data_rx), .st_end(st_end),
        .st_acked(st_acked), .st_abort(st_abort), .irq(irq)
    );

    typedef struct packed {
        logic       rx, ack, evt, clr, flag;
        logic [7:0] b;
        logic       e_data, e_end, e_acked, e_abort, e_ack;
        logic [7:0] e_dout;
        logic       e_irq;
    } vec_t;

    localparam int NV = 27;
    // rx ack evt clr flag byte | data end acked abort ack dout irq
    localparam vec_t VECS [NV] = '{
        // every-byte mode, two-byte packet, handshake (R3, R5, R6)
        '{1,1,1,0,0,8'hA1, 1,0,0,0,0,8'hA1,1},
        '{1,1,1,1,1,8'h00, 0,0,1,0,1,8'hA1,1},
        '{1,1,1,1,0,8'hB2, 1,0,0,0,0,8'hB2,1},
        '{1,1,1,1,1,8'h00, 0,0,1,0,1,8'hB2,1},
        '{1,1,1,1,1,8'h00, 0,1,0,0,1,8'hB2,1},
        // overrun abort with ack hold (R7), then end (R6)
        '{1,1,1,1,0,8'hC3, 1,0,0,0,0,8'hC3,1},
        '{1,1,1,0,1,8'h00, 1,0,1,0,1,8'hC3,1},
        '{1,1,1,0,0,8'hD4, 1,0,1,1,1,8'hC3,1},
        '{1,1,1,0,1,8'h00, 1,0,1,1,1,8'hC3,1},
        '{1,1,1,1,1,8'h00, 0,1,0,0,1,8'hC3,1},
        // event enable gating (R8)
        '{1,1,0,1,1,8'h00, 0,0,0,0,1,8'hC3,0},
        '{1,1,0,0,0,8'hE5, 1,0,0,0,0,8'hE5,1},
        '{1,1,0,1,1,8'h00, 0,0,1,0,1,8'hE5,0},
        '{1,1,0,0,1,8'h00, 0,1,1,0,1,8'hE5,0},
        '{1,1,1,0,1,8'h00, 0,1,1,0,1,8'hE5,1},
        // first-byte-only mode, ack idle (R2, R5)
        '{1,0,0,1,0,8'hF6, 1,0,0,0,1,8'hF6,1},
        '{1,0,0,1,1,8'h00, 0,0,0,0,1,8'hF6,0},
        '{1,0,0,0,0,8'h07, 0,0,0,0,1,8'hF6,0},
        '{1,0,0,0,1,8'h00, 0,0,0,0,1,8'hF6,0},
        '{1,0,0,0,1,8'h00, 0,1,0,0,1,8'hF6,0},
        '{1,0,0,1,0,8'h18, 1,0,0,0,1,8'h18,1},
        // receive disabled (R1)
        '{0,0,1,1,1,8'h00, 0,0,0,0,1,8'h18,0},
        '{0,0,1,0,1,8'h00, 0,1,0,0,1,8'h18,1},
        '{0,0,1,1,0,8'h29, 0,0,0,0,1,8'h18,0},
        '{0,0,1,0,1,8'h00, 0,0,0,0,1,8'h18,0},
        '{0,0,1,0,1,8'h00, 0,1,0,0,1,8'h18,1},
        '{0,1,1,1,0,8'h3A, 0,0,0,0,1,8'h18,0}
    };

    task automatic check(input string req, input logic ed, ee, ea, eb, ek,
                         input logic [7:0] eo, input logic ei);
        n_chk++;
        if ({st_data_rx, st_end, st_acked, st_abort, ack_flag, data_out, irq} !==
            {ed, ee, ea, eb, ek, eo, ei}) begin
            n_bad++;
            $display("FAIL %s: got data=%b end=%b acked=%b abort=%b ack=%b dout=%h irq=%b, exp data=%b end=%b acked=%b abort=%b ack=%b dout=%h irq=%b",
                     req, st_data_rx, st_end, st_acked, st_abort, ack_flag, data_out, irq,
                     ed, ee, ea, eb, ek, eo, ei);
        end
    endtask

    task automatic clr_pulse();
        @(negedge clk); rd_clr = 1'b1;
        @(negedge clk); rd_clr = 1'b0;
    endtask

    task automatic frame(input logic f, input logic [7:0] b, input logic clr_same);
        @(negedge clk);
        sender_flag = f; rx_byte = b; frame_stb = 1'b1; rd_clr = clr_same;
        @(negedge clk);
        frame_stb = 1'b0; rd_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset", 0, 0, 0, 0, 1, 8'h00, 0);

        for (int i = 0; i < NV; i++) begin
            en_rx_irq = VECS[i].rx; en_ack_ctrl = VECS[i].ack; en_evt_irq = VECS[i].evt;
            if (VECS[i].clr) clr_pulse();
            frame(VECS[i].flag, VECS[i].b, 1'b0);
            check($sformatf("vector %0d (R1 R2 R3 R5 R6 R7 R8 R9)", i),
                  VECS[i].e_data, VECS[i].e_end, VECS[i].e_acked, VECS[i].e_abort,
                  VECS[i].e_ack, VECS[i].e_dout, VECS[i].e_irq);
        end

        // R4: flag and byte changes without a strobe are ignored
        en_rx_irq = 1; en_ack_ctrl = 1; en_evt_irq = 1;
        clr_pulse();
        @(negedge clk); sender_flag = 1'b1; rx_byte = 8'h77;
        repeat (3) @(negedge clk);
        sender_flag = 1'b0;
        repeat (3) @(negedge clk);
        check("R4 no strobe", 0, 0, 0, 0, 1, 8'h18, 0);
        frame(1'b1, 8'h00, 1'b0);
        check("R4 rise no ack", 0, 0, 0, 0, 1, 8'h18, 0);
        frame(1'b0, 8'h4B, 1'b0);
        check("R4 byte on strobe", 1, 0, 0, 0, 0, 8'h4B, 1);
        frame(1'b1, 8'h00, 1'b0);
        check("R5 release", 1, 0, 1, 0, 1, 8'h4B, 1);

        // R7/R9: read/clear coincides with the next byte's strobe
        frame(1'b0, 8'h5C, 1'b1);
        check("R7 R9 same-cycle read", 1, 0, 0, 0, 0, 8'h5C, 1);

        // R9: stand-alone clear empties every flag
        frame(1'b1, 8'h00, 1'b0);
        clr_pulse();
        check("R9 clear", 0, 0, 0, 0, 1, 8'h5C, 0);

        finish_run();
    end
endmodule